// File: doc/BRIEF.md
# Multidrop Express Network Router

This block is one router of a concentrated two-dimensional network whose row and column channels each reach several downstream nodes. At the default radix of four with four terminals per node, the router has six network inputs and four local injection inputs. Every input has its own flit buffer. The network inputs are grouped by the side they arrive from, and each group reaches the switch through a single shared port. The switch therefore has eight inputs (four sides and four terminals) and eight outputs (one per direction and one per terminal).

Packets are wormhole-switched with one buffer per input, so the router has no virtual channel stage. The head flit selects the output in dimension order: X first, then Y, then the local terminal. Two rounds of round-robin arbitration pick the flits: the first round chooses one input inside each side group, and the second chooses one group for each output. Both choices are held until the tail flit has passed. Each output counts its downstream credits. Each input returns a one-cycle credit pulse for every flit that leaves its buffer.

Top module: `mxr_router`

## Requirements
- R1: While reset is high and in the cycle after it, every bit of `out_valid` and `credit_out` is 0.
- R2: A flit is 16 bits wide. Bit 15 marks a head flit and bit 14 a tail flit. Bits 13:12 hold the destination x, bits 11:10 the destination y, bits 9:8 the terminal index and bits 7:0 the payload. With no contention, a flit presented at an input in cycle n appears on its output in cycle n+3, unchanged.
- R3: A head flit whose x differs from the router's x (default 1) leaves on output 0 if its x is larger and on output 1 if its x is smaller, whatever its y.
- R4: A head flit with a matching x and a differing y leaves on output 2 if its y is larger and on output 3 if its y is smaller.
- R5: A head flit with matching x and y leaves on output 4 plus its terminal index.
- R6: Body and tail flits follow their head's output regardless of their own address bits. An output accepts no flit from another packet until the current packet's tail has passed.
- R7: Each output starts with 10 credits. An output with no credits sends nothing, and every pulse on `credit_in` allows one more flit through.
- R8: `credit_out` for an input pulses once for each flit that leaves that input's buffer.
- R9: Inputs that share a side (inputs 0 and 1 arrive from +x, input 2 from -x, inputs 3 and 4 from +y, input 5 from -y, and inputs 6 to 9 from terminals 0 to 3) forward at most one flit per cycle between them, even when they target different outputs.
- R10: When two packets from different groups contend for the same output, both are delivered and none is lost.
- R11: An upstream sender must not push a flit into a full input buffer unless a flit leaves that buffer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 10 | Flit present on each input |
| in_flit | input | 160 | Flit per input; input i occupies bits 16i+15 down to 16i |
| credit_out | output | 10 | One-cycle credit pulse back to each input's sender |
| out_valid | output | 8 | Flit present on each output |
| out_flit | output | 128 | Flit per output, packed the same way as the inputs |
| credit_in | input | 8 | Credit returned by each output's receiver |

## Verification
The assertions check, on every cycle, that no output sends without a credit and that no credit count rises above the buffer depth. They also check that a shared side port never feeds two outputs at once, that a locked output accepts only from its owner, and that no buffer overflows or underflows. Only the bench scenarios can show which output each address reaches, the three-cycle timing, and that a wormhole packet reaches its output in one unbroken run. They also show that the credit stall holds back exactly the eleventh flit and that contending packets all arrive.

// File: rtl/mxr_pkg.sv
`timescale 1ns/1ps
package mxr_pkg;
  parameter int K     = 4;
  parameter int CONC  = 4;
  parameter int PAY_W = 8;
  localparam int CW   = $clog2(K);
  localparam int TW   = $clog2(CONC);
  localparam int NDIR = 4;
  localparam int NOUT = NDIR + CONC;
  localparam int OW   = $clog2(NOUT);

  typedef struct packed {
    logic             head;
    logic             tail;
    logic [CW-1:0]    x;
    logic [CW-1:0]    y;
    logic [TW-1:0]    term;
    logic [PAY_W-1:0] pay;
  } flit_t;

  localparam int FW = $bits(flit_t);

  // dimension order: X first, then Y, then local terminal
  function automatic logic [OW-1:0] route_out(flit_t f, logic [CW-1:0] mx, logic [CW-1:0] my);
    if (f.x != mx)      return (f.x > mx) ? OW'(0) : OW'(1);
    else if (f.y != my) return (f.y > my) ? OW'(2) : OW'(3);
    else                return OW'(NDIR) + OW'(f.term);
  endfunction
endpackage

// File: rtl/mxr_fifo.sv
`timescale 1ns/1ps
module mxr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic          full;

  assign empty = (cnt == '0);
  assign full  = (cnt == NW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + NW'(push) - NW'(pop);
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) (push && full) |-> pop);  // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);          // R8
endmodule

// File: rtl/mxr_rr_arb.sv
`timescale 1ns/1ps
module mxr_rr_arb #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic                 gnt_v,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IW = $clog2(N);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_v   = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (int'(ptr) + i) % N;
      if (!gnt_v && req[j]) begin
        gnt_v   = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv && gnt_v) ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/mxr_router.sv
`timescale 1ns/1ps
module mxr_router
  import mxr_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int MY_X  = 1,
  parameter int MY_Y  = 1,
  parameter int NIN   = 2 * (K - 1),
  parameter logic [2*NIN-1:0] IN_DIR = {2'd3, 2'd2, 2'd2, 2'd1, 2'd0, 2'd0}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NIN+CONC-1:0]        in_valid,
  input  logic [(NIN+CONC)*FW-1:0]   in_flit,
  output logic [NIN+CONC-1:0]        credit_out,
  output logic [NOUT-1:0]            out_valid,
  output logic [NOUT*FW-1:0]         out_flit,
  input  logic [NOUT-1:0]            credit_in
);
  localparam int NF  = NIN + CONC;
  localparam int NG  = NDIR + CONC;
  localparam int FIW = $clog2(NF);
  localparam int GIW = $clog2(NG);
  localparam int CRW = $clog2(DEPTH + 1);

  function automatic int grp_of(int i);
    if (i < NIN) return int'(IN_DIR[2*i +: 2]);
    else         return NDIR + (i - NIN);
  endfunction

  // input buffers
  logic [FW-1:0]  hd_raw [NF];
  flit_t          hd     [NF];
  logic [NF-1:0]  empty, pop;
  logic [OW-1:0]  rt_hold [NF];
  logic [OW-1:0]  rt_cur  [NF];

  for (genvar i = 0; i < NF; i++) begin : g_in
    mxr_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(in_valid[i]), .din(in_flit[i*FW +: FW]),
      .pop(pop[i]), .dout(hd_raw[i]), .empty(empty[i])
    );
    assign hd[i]     = flit_t'(hd_raw[i]);
    assign rt_cur[i] = hd[i].head ? route_out(hd[i], CW'(MY_X), CW'(MY_Y)) : rt_hold[i];
  end

  // level 1: one input per side group
  logic [NF-1:0]  greq [NG];
  logic [NG-1:0]  gav, gadv, ggnt, glock, cand_v;
  logic [FIW-1:0] gaidx [NG];
  logic [FIW-1:0] glock_idx [NG];
  logic [FIW-1:0] cand_i [NG];
  logic [OW-1:0]  cand_rt [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_comb begin
      for (int i = 0; i < NF; i++) greq[g][i] = (grp_of(i) == g) && !empty[i];
    end
    mxr_rr_arb #(.N(NF)) u_garb (
      .clk(clk), .rst(rst), .req(greq[g]), .adv(gadv[g]),
      .gnt_v(gav[g]), .gnt_idx(gaidx[g])
    );
    assign cand_i[g]  = glock[g] ? glock_idx[g] : gaidx[g];
    assign cand_v[g]  = glock[g] ? !empty[glock_idx[g]] : gav[g];
    assign cand_rt[g] = rt_cur[cand_i[g]];
    assign gadv[g]    = ggnt[g] && !glock[g];
  end

  // level 2: one group per output
  logic [NG-1:0]   oreq [NOUT];
  logic [NOUT-1:0] ogv, olock;
  logic [GIW-1:0]  ogidx  [NOUT];
  logic [GIW-1:0]  olock_g [NOUT];
  logic [CRW-1:0]  cred   [NOUT];
  flit_t           st1_f  [NOUT];
  flit_t           out_f  [NOUT];
  logic [NOUT-1:0] st1_v;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    always_comb begin
      for (int g = 0; g < NG; g++)
        oreq[o][g] = cand_v[g] && (cand_rt[g] == OW'(o)) && (cred[o] != '0) &&
                     (!olock[o] || (olock_g[o] == GIW'(g)));
    end
    mxr_rr_arb #(.N(NG)) u_oarb (
      .clk(clk), .rst(rst), .req(oreq[o]), .adv(!olock[o]),
      .gnt_v(ogv[o]), .gnt_idx(ogidx[o])
    );
    assign out_flit[o*FW +: FW] = out_f[o];

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst) cred[o] <= CRW'(DEPTH));  // R7
    AST_NO_SEND_DRY:  assert property (@(posedge clk) disable iff (rst) ogv[o] |-> cred[o] != '0); // R7
    AST_WORM_OWNER:   assert property (@(posedge clk) disable iff (rst)
                        (olock[o] && ogv[o]) |-> ogidx[o] == olock_g[o]);                          // R6
  end

  always_comb begin
    ggnt = '0;
    pop  = '0;
    for (int o = 0; o < NOUT; o++)
      if (ogv[o]) ggnt[ogidx[o]] = 1'b1;
    for (int g = 0; g < NG; g++)
      if (ggnt[g]) pop[cand_i[g]] = 1'b1;
  end

  for (genvar g = 0; g < NG; g++) begin : g_chk
    logic [NOUT-1:0] users;
    always_comb begin
      for (int o = 0; o < NOUT; o++) users[o] = ogv[o] && (ogidx[o] == GIW'(g));
    end
    AST_ONE_PER_PORT: assert property (@(posedge clk) disable iff (rst) $onehot0(users));  // R9
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glock      <= '0;
      olock      <= '0;
      st1_v      <= '0;
      out_valid  <= '0;
      credit_out <= '0;
      for (int g = 0; g < NG; g++) glock_idx[g] <= '0;
      for (int o = 0; o < NOUT; o++) begin
        olock_g[o] <= '0;
        cred[o]    <= CRW'(DEPTH);
        st1_f[o]   <= '0;
        out_f[o]   <= '0;
      end
      for (int i = 0; i < NF; i++) rt_hold[i] <= '0;
    end else begin
      credit_out <= pop;
      for (int i = 0; i < NF; i++)
        if (pop[i] && hd[i].head) rt_hold[i] <= rt_cur[i];
      for (int g = 0; g < NG; g++) begin
        if (ggnt[g]) begin
          if (hd[cand_i[g]].tail) glock[g] <= 1'b0;
          else if (hd[cand_i[g]].head) begin
            glock[g]     <= 1'b1;
            glock_idx[g] <= cand_i[g];
          end
        end
      end
      for (int o = 0; o < NOUT; o++) begin
        cred[o] <= cred[o] - CRW'(ogv[o]) + CRW'(credit_in[o]);
        if (ogv[o]) begin
          if (hd[cand_i[ogidx[o]]].tail) olock[o] <= 1'b0;
          else if (hd[cand_i[ogidx[o]]].head) begin
            olock[o]   <= 1'b1;
            olock_g[o] <= ogidx[o];
          end
        end
        st1_v[o]     <= ogv[o];
        st1_f[o]     <= hd[cand_i[ogidx[o]]];
        out_valid[o] <= st1_v[o];
        out_f[o]     <= st1_f[o];
      end
    end
  end
endmodule

// File: tb/sim_mxr_router.sv
`timescale 1ns/1ps
module sim_mxr_router;
  import mxr_pkg::*;
  localparam int NF = 10;
  localparam int NO = 8;

  typedef struct packed {
    logic [3:0] src;
    logic [1:0] dx;
    logic [1:0] dy;
    logic [1:0] dt;
    logic [2:0] exp_o;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'd2, 2'd3, 2'd0, 2'd0, 3'd0},
    '{4'd0, 2'd0, 2'd3, 2'd0, 3'd1},
    '{4'd3, 2'd1, 2'd2, 2'd0, 3'd2},
    '{4'd5, 2'd1, 2'd0, 2'd0, 3'd3},
    '{4'd6, 2'd1, 2'd1, 2'd0, 3'd4},
    '{4'd7, 2'd1, 2'd1, 2'd1, 3'd5},
    '{4'd8, 2'd1, 2'd1, 2'd2, 3'd6},
    '{4'd9, 2'd1, 2'd1, 2'd3, 3'd7},
    '{4'd4, 2'd2, 2'd2, 2'd0, 3'd0},
    '{4'd1, 2'd0, 2'd0, 2'd0, 3'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NF-1:0]    in_valid = '0;
  logic [NF*FW-1:0] in_flit  = '0;
  logic [NF-1:0]    credit_out;
  logic [NO-1:0]    out_valid;
  logic [NO*FW-1:0] out_flit;
  logic [NO-1:0]    credit_in = '0;
  logic [NO-1:0]    man_cred  = '0;
  logic             auto_ret  = 1'b1;

  int nchk = 0, nfail = 0, cyc = 0, nlog = 0, crd_total = 0;
  int lg_o [64];
  int lg_p [64];
  int lg_c [64];

  always #2.5 clk = ~clk;

  mxr_router u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .credit_out(credit_out), .out_valid(out_valid), .out_flit(out_flit),
    .credit_in(credit_in)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    credit_in <= (auto_ret ? out_valid : '0) | man_cred;
  end

  always @(negedge clk) begin
    crd_total = crd_total + $countones(credit_out);
    for (int o = 0; o < NO; o++) begin
      if (out_valid[o] && nlog < 64) begin
        lg_o[nlog] = o;
        lg_p[nlog] = int'(out_flit[o*FW +: 8]);
        lg_c[nlog] = cyc;
        nlog = nlog + 1;
      end
    end
  end

  function automatic flit_t mk(logic h, logic t, logic [1:0] x, logic [1:0] y, logic [1:0] term, logic [7:0] p);
    flit_t f;
    f.head = h; f.tail = t; f.x = x; f.y = y; f.term = term; f.pay = p;
    return f;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    @(negedge clk);
    #1;
    nlog = 0;
    crd_total = 0;
  endtask

  function automatic int count_out(int o);
    int c = 0;
    for (int k = 0; k < nlog; k++) if (lg_o[k] == o) c++;
    return c;
  endfunction

  initial begin
    bit done;
    done = 1'b0;
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          nchk++; nfail++;
          $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
          $display("%0d/%0d checks passed", nchk - nfail, nchk);
          $finish;
        end
      end
    join_none

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(out_valid == '0 && credit_out == '0, "R1 during reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0 && credit_out == '0, "R1 after reset", int'(credit_out), 0);

    // R2..R5, R8: routing table walk
    clear_log();
    foreach (VEC[v]) begin
      string tag;
      flit_t got;
      @(negedge clk);
      in_valid[VEC[v].src] = 1'b1;
      in_flit[VEC[v].src*FW +: FW] = mk(1'b1, 1'b1, VEC[v].dx, VEC[v].dy, VEC[v].dt, 8'(8'h10 + v));
      @(negedge clk);
      in_valid = '0;
      @(negedge clk);
      @(negedge clk);
      got = flit_t'(out_flit[VEC[v].exp_o*FW +: FW]);
      tag = (VEC[v].exp_o >= 4) ? "R2 R5 route" : (VEC[v].dx != 2'd1) ? "R2 R3 route" : "R2 R4 route";
      chk(out_valid == (NO'(1) << VEC[v].exp_o), tag, int'(out_valid), 1 << VEC[v].exp_o);
      chk(got.pay == 8'(8'h10 + v) && got.head && got.tail, "R2 payload", int'(got.pay), 16 + v);
      idle(3);
    end
    #1;
    chk(crd_total == 10, "R8 credit pulses", crd_total, 10);

    // R9: two inputs of the +x side, different outputs
    clear_log();
    in_valid[0] = 1'b1; in_flit[0*FW +: FW] = mk(1, 1, 2'd0, 2'd1, 2'd0, 8'hC0);
    in_valid[1] = 1'b1; in_flit[1*FW +: FW] = mk(1, 1, 2'd1, 2'd1, 2'd0, 8'hC1);
    @(negedge clk);
    in_valid = '0;
    idle(10);
    #1;
    chk(nlog == 2, "R9 both delivered", nlog, 2);
    chk(nlog == 2 && lg_c[0] != lg_c[1], "R9 shared port serialises", lg_c[1] - lg_c[0], 1);
    chk(crd_total == 2, "R8 credit pulses shared", crd_total, 2);

    // R6: wormhole packet plus competitor on output 0
    clear_log();
    in_valid[2] = 1'b1; in_flit[2*FW +: FW] = mk(1, 0, 2'd3, 2'd0, 2'd0, 8'hA0);
    in_valid[6] = 1'b1; in_flit[6*FW +: FW] = mk(1, 1, 2'd3, 2'd0, 2'd0, 8'hB0);
    @(negedge clk);
    in_valid = '0;
    in_valid[2] = 1'b1; in_flit[2*FW +: FW] = mk(0, 0, 2'd1, 2'd1, 2'd0, 8'hA1);
    @(negedge clk);
    in_valid[2] = 1'b1; in_flit[2*FW +: FW] = mk(0, 1, 2'd1, 2'd1, 2'd2, 8'hA2);
    @(negedge clk);
    in_valid = '0;
    idle(12);
    #1;
    chk(nlog == 4 && count_out(0) == 4, "R6 body follows head", count_out(0), 4);
    begin
      int pa;
      pa = -1;
      for (int k = 0; k < nlog; k++) if (lg_p[k] == 'hA0) pa = k;
      chk(pa >= 0 && pa + 2 < nlog && lg_p[pa+1] == 'hA1 && lg_p[pa+2] == 'hA2,
          "R6 no interleave", pa, 0);
    end

    // R10: two groups contend for output 5
    clear_log();
    in_valid[2] = 1'b1; in_flit[2*FW +: FW] = mk(1, 1, 2'd1, 2'd1, 2'd1, 8'hD0);
    in_valid[3] = 1'b1; in_flit[3*FW +: FW] = mk(1, 1, 2'd1, 2'd1, 2'd1, 8'hD1);
    @(negedge clk);
    in_valid = '0;
    idle(10);
    #1;
    chk(count_out(5) == 2, "R10 both delivered", count_out(5), 2);
    chk(nlog == 2 && lg_p[0] + lg_p[1] == 'hD0 + 'hD1 && lg_c[0] != lg_c[1],
        "R10 payloads", lg_p[0] + lg_p[1], 'hD0 + 'hD1);

    // R7: credit exhaustion on output 4
    clear_log();
    auto_ret = 1'b0;
    idle(2);
    for (int n = 0; n < 11; n++) begin
      in_valid[6] = 1'b1;
      in_flit[6*FW +: FW] = mk(1, 1, 2'd1, 2'd1, 2'd0, 8'(8'h40 + n));
      @(negedge clk);
    end
    in_valid = '0;
    idle(15);
    #1;
    chk(count_out(4) == 10, "R7 stall at zero credit", count_out(4), 10);
    @(negedge clk);
    man_cred[4] = 1'b1;
    @(negedge clk);
    man_cred = '0;
    idle(8);
    #1;
    chk(count_out(4) == 11, "R7 resume after credit", count_out(4), 11);
    chk(nlog > 0 && lg_p[nlog-1] == 'h4A, "R7 last flit", lg_p[nlog > 0 ? nlog-1 : 0], 'h4A);
    chk(crd_total == 11, "R8 credit pulses stream", crd_total, 11);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule